// File: doc/BRIEF.md
# Banked Host Register Window for a Network Controller

This block is the byte-wide host port of a small network controller. Sixteen byte addresses are visible to the host. One of them, the bank selector, switches the remaining addresses between four register banks. The banks hold transmit and receive control, configuration, general-purpose and control words, the host packet number, a packet-memory pointer with a data port, and the interrupt status, mask and acknowledge registers. The block drives a level interrupt that is the OR of the unmasked status bits.

Packet memory lies outside the block. The block forms the memory address from the pointer register and a page number, and it issues the write strobe and data. Read data from memory is passed back to the host on a data-port read. The queue and allocator logic also lies outside. It supplies the queue heads, the allocation result, the allocated-page count and the interrupt events. A write to the command register is passed to that logic as a strobe with a 3-bit code. A TX acknowledge is passed back to it as a pop pulse. A host access is one cycle long and takes either `wr_i` or `rd_i`. A 16-bit host access is issued as two byte accesses, low address first.

Top module: `nic_host_regs`

## Requirements
- R1: Offset 14 is the bank selector in every bank: a write stores wdata[1:0] and a read returns it. Offset 15 always reads 0x33, and writes to it change nothing.
- R2: After reset: bank 0, transmit control (bank 0 offsets 0/1) 0, receive control (bank 0 offsets 4/5) 0, configuration (bank 1 offsets 0/1) 0xA0B1, control (bank 1 offsets 12/13) 0x1210, pointer (bank 2 offsets 6/7) 0, early-receive threshold (bank 3 offset 12, 5 bits) 0x1F, status (bank 2 offset 12) 0x04 only, mask (bank 2 offset 13) 0.
- R3: Data-port accesses (bank 2 offsets 8 to 11) address memory at {page, byte}. The page is rx_head_i[1:0] when pointer bit 15 is set. Otherwise it is the packet-number register (bank 2 offset 2) bits 1:0.
- R4: With pointer bit 14 set, the byte address is pointer[10:0]. Each data-port read or write then adds 1 to pointer[10:0], wrapping at 11 bits, and leaves pointer[15:11] unchanged.
- R5: With pointer bit 14 clear, the byte address is (pointer[10:0] + offset[1:0]) mod 2048, and the pointer does not change.
- R6: A write to bank 2 offset 12 clears the status bits in wdata & 0xD6. When wdata bit 1 is set, tx_done_pop_o pulses in the same cycle.
- R7: irq_o is high exactly when (status & mask) is non-zero. irq_set_i bits set status bits. Status bit 2 is held set while txq_empty_i is high, and status bit 1 is held set while txdone_ne_i is high.
- R8: A write to bank 0 offset 5 with wdata bit 7 set pulses soft_rst_o and returns every register to its R2 value on the next cycle.
- R9: The pointer high byte reads masked with 0xF7. Bank 3 offset 10 reads 0x91. Bank 0 offset 8 reads the page count 4. Bank 0 offset 9 reads alloc_cnt_i.
- R10: A write to the control low byte (bank 1 offset 12) stores wdata with bits 1:0 cleared.
- R11: A write to bank 2 offset 0 pulses mmu_cmd_vld_o with mmu_cmd_o = wdata[7:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Host byte offset |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| mem_addr_o | output | 13 | Packet memory address {page, byte} |
| mem_we_o | output | 1 | Packet memory write enable |
| mem_wdata_o | output | 8 | Packet memory write data |
| mem_rdata_i | input | 8 | Packet memory read data |
| rx_head_i | input | 8 | RX queue head (0x80 when empty) |
| tx_done_head_i | input | 8 | TX-done queue head (0x80 when empty) |
| alloc_res_i | input | 8 | Last allocation result |
| alloc_cnt_i | input | 8 | Number of allocated pages |
| irq_set_i | input | 8 | Interrupt event pulses |
| txq_empty_i | input | 1 | TX queue is empty |
| txdone_ne_i | input | 1 | TX-done queue is non-empty |
| mmu_cmd_vld_o | output | 1 | Command strobe |
| mmu_cmd_o | output | 3 | Command code |
| tx_done_pop_o | output | 1 | Pop the TX-done queue |
| soft_rst_o | output | 1 | Soft reset pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that wr_i and rd_i are never high together, so a cycle holds at most one host access. They also assume that irq_set_i does not raise a status bit in the same cycle an acknowledge clears it. The stimulus drives a single strobe per access from tasks. It raises interrupt events only in cycles with no acknowledge write, and it holds the queue-state inputs steady around each check. Pointer runs start next to the 2047 boundary to exercise both the increment wrap and the offset-sum wrap.

// File: rtl/bhi_pkg.sv
package bhi_pkg;
  localparam logic [15:0] CFG_RST  = 16'hA0B1;
  localparam logic [15:0] CTL_RST  = 16'h1210;
  localparam logic [4:0]  ERCV_RST = 5'h1F;
  localparam logic [7:0]  STAT_RST = 8'h04;
  localparam logic [7:0]  ACK_MSK  = 8'hD6;
  localparam logic [7:0]  PHI_MSK  = 8'hF7;
  localparam logic [7:0]  REV_ID   = 8'h91;
  localparam logic [3:0]  OFF_BANK = 4'd14;
  localparam logic [3:0]  OFF_SIG  = 4'd15;
  typedef enum logic [1:0] {BK_CTRL, BK_CFG, BK_PKT, BK_MISC} bank_e;
endpackage

// File: rtl/bhi_ptr.sv
module bhi_ptr #(
  parameter int PG_W = 2,
  parameter int BY_W = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 wr_lo_i,
  input  logic                 wr_hi_i,
  input  logic [7:0]           wdata_i,
  input  logic                 acc_i,
  input  logic [1:0]           lane_i,
  input  logic [PG_W-1:0]      rx_page_i,
  input  logic [PG_W-1:0]      pn_page_i,
  output logic [15:0]          ptr_o,
  output logic [PG_W+BY_W-1:0] mem_addr_o
);
  logic [15:0]     ptr_q;
  logic [BY_W-1:0] byte_a;
  logic [PG_W-1:0] page;

  assign page   = ptr_q[15] ? rx_page_i : pn_page_i;
  assign byte_a = ptr_q[14] ? ptr_q[BY_W-1:0] : ptr_q[BY_W-1:0] + BY_W'(lane_i);
  assign mem_addr_o = {page, byte_a};
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (clr_i)    ptr_q <= '0;
    else if (wr_lo_i)  ptr_q[7:0] <= wdata_i;
    else if (wr_hi_i)  ptr_q[15:8] <= wdata_i;
    else if (acc_i && ptr_q[14])
      ptr_q[BY_W-1:0] <= ptr_q[BY_W-1:0] + 1'b1;  // upper bits kept
  end
endmodule

// File: rtl/bhi_irq.sv
module bhi_irq
  import bhi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       ack_we_i,
  input  logic       mask_we_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] set_i,
  input  logic       txq_empty_i,
  input  logic       txdone_ne_i,
  output logic [7:0] stat_o,
  output logic [7:0] mask_o,
  output logic       pop_o,
  output logic       irq_o
);
  logic [7:0] stat_q, mask_q, clr_bits, force_bits;

  assign clr_bits   = ack_we_i ? (wdata_i & ACK_MSK) : 8'h00;
  assign force_bits = {5'b0, txq_empty_i, txdone_ne_i, 1'b0};
  assign pop_o      = ack_we_i & wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_RST;
      mask_q <= '0;
    end else if (clr_i) begin
      stat_q <= STAT_RST;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | set_i | force_bits;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);
endmodule

// File: rtl/nic_host_regs.sv
module nic_host_regs
  import bhi_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int PG_W = $clog2(PAGES),
  localparam int BY_W = $clog2(PAGE_BYTES),
  localparam int AW   = PG_W + BY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic [7:0]    rx_head_i,
  input  logic [7:0]    tx_done_head_i,
  input  logic [7:0]    alloc_res_i,
  input  logic [7:0]    alloc_cnt_i,
  input  logic [7:0]    irq_set_i,
  input  logic          txq_empty_i,
  input  logic          txdone_ne_i,
  output logic          mmu_cmd_vld_o,
  output logic [2:0]    mmu_cmd_o,
  output logic          tx_done_pop_o,
  output logic          soft_rst_o,
  output logic          irq_o
);
  bank_e       bank_q;
  logic [15:0] tcr_q, rcr_q, cfg_q, ctl_q, gp_q, ptr_q;
  logic [7:0]  pnum_q, stat_q, mask_q;
  logic [4:0]  ercv_q;
  logic        banked, data_sel, soft_clr;
  logic        w0, w1, w2, w3;

  assign banked   = (addr_i != OFF_BANK) && (addr_i != OFF_SIG);
  assign w0       = wr_i && banked && bank_q == BK_CTRL;
  assign w1       = wr_i && banked && bank_q == BK_CFG;
  assign w2       = wr_i && banked && bank_q == BK_PKT;
  assign w3       = wr_i && banked && bank_q == BK_MISC;
  assign data_sel = banked && bank_q == BK_PKT && addr_i[3:2] == 2'b10;
  assign soft_clr = w0 && addr_i == 4'd5 && wdata_i[7];

  assign soft_rst_o    = soft_clr;
  assign mmu_cmd_vld_o = w2 && addr_i == 4'd0;
  assign mmu_cmd_o     = wdata_i[7:5];
  assign mem_we_o      = wr_i && data_sel;
  assign mem_wdata_o   = wdata_i;

  bhi_ptr #(.PG_W(PG_W), .BY_W(BY_W)) u_ptr (
    .clk_i, .rst_ni,
    .clr_i     (soft_clr),
    .wr_lo_i   (w2 && addr_i == 4'd6),
    .wr_hi_i   (w2 && addr_i == 4'd7),
    .wdata_i,
    .acc_i     ((wr_i || rd_i) && data_sel),
    .lane_i    (addr_i[1:0]),
    .rx_page_i (rx_head_i[PG_W-1:0]),
    .pn_page_i (pnum_q[PG_W-1:0]),
    .ptr_o     (ptr_q),
    .mem_addr_o
  );

  bhi_irq u_irq (
    .clk_i, .rst_ni,
    .clr_i     (soft_clr),
    .ack_we_i  (w2 && addr_i == 4'd12),
    .mask_we_i (w2 && addr_i == 4'd13),
    .wdata_i,
    .set_i     (irq_set_i),
    .txq_empty_i, .txdone_ne_i,
    .stat_o    (stat_q),
    .mask_o    (mask_q),
    .pop_o     (tx_done_pop_o),
    .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || soft_clr) begin
      bank_q <= BK_CTRL;
      tcr_q  <= '0;
      rcr_q  <= '0;
      cfg_q  <= CFG_RST;
      ctl_q  <= CTL_RST;
      gp_q   <= '0;
      pnum_q <= '0;
      ercv_q <= ERCV_RST;
    end else if (wr_i) begin
      if (addr_i == OFF_BANK) bank_q <= bank_e'(wdata_i[1:0]);
      if (w0) case (addr_i)
        4'd0: tcr_q[7:0]  <= wdata_i;
        4'd1: tcr_q[15:8] <= wdata_i;
        4'd4: rcr_q[7:0]  <= wdata_i;
        4'd5: rcr_q[15:8] <= wdata_i;
        default: ;
      endcase
      if (w1) case (addr_i)
        4'd0:  cfg_q[7:0]  <= wdata_i;
        4'd1:  cfg_q[15:8] <= wdata_i;
        4'd10: gp_q[7:0]   <= wdata_i;
        4'd11: gp_q[15:8]  <= wdata_i;
        4'd12: ctl_q[7:0]  <= {wdata_i[7:2], 2'b00};
        4'd13: ctl_q[15:8] <= wdata_i;
        default: ;
      endcase
      if (w2 && addr_i == 4'd2) pnum_q <= wdata_i;
      if (w3 && addr_i == 4'd12) ercv_q <= wdata_i[4:0];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == OFF_BANK)     rdata_o = {6'b0, bank_q};
    else if (addr_i == OFF_SIG) rdata_o = 8'h33;
    else begin
      unique case (bank_q)
        BK_CTRL: case (addr_i)
          4'd0: rdata_o = tcr_q[7:0];
          4'd1: rdata_o = tcr_q[15:8];
          4'd3: rdata_o = 8'h40;
          4'd4: rdata_o = rcr_q[7:0];
          4'd5: rdata_o = rcr_q[15:8];
          4'd8: rdata_o = 8'(PAGES);
          4'd9: rdata_o = alloc_cnt_i;
          default: ;
        endcase
        BK_CFG: case (addr_i)
          4'd0:  rdata_o = cfg_q[7:0];
          4'd1:  rdata_o = cfg_q[15:8];
          4'd10: rdata_o = gp_q[7:0];
          4'd11: rdata_o = gp_q[15:8];
          4'd12: rdata_o = ctl_q[7:0];
          4'd13: rdata_o = ctl_q[15:8];
          default: ;
        endcase
        BK_PKT: case (addr_i)
          4'd2:  rdata_o = pnum_q;
          4'd3:  rdata_o = alloc_res_i;
          4'd4:  rdata_o = tx_done_head_i;
          4'd5:  rdata_o = rx_head_i;
          4'd6:  rdata_o = ptr_q[7:0];
          4'd7:  rdata_o = ptr_q[15:8] & PHI_MSK;
          4'd8, 4'd9, 4'd10, 4'd11: rdata_o = mem_rdata_i;
          4'd12: rdata_o = stat_q;
          4'd13: rdata_o = mask_q;
          default: ;
        endcase
        BK_MISC: case (addr_i)
          4'd8:  rdata_o = 8'h30;
          4'd9:  rdata_o = 8'h33;
          4'd10: rdata_o = REV_ID;
          4'd11: rdata_o = 8'h33;
          4'd12: rdata_o = {3'b0, ercv_q};
          default: ;
        endcase
      endcase
    end
  end
endmodule

// File: rtl/bhi_checks.sv
module bhi_checks (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  addr_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  irq_set_i,
  input logic [1:0]  bank_q,
  input logic [15:0] ptr_q,
  input logic [7:0]  stat_q,
  input logic        irq_o,
  input logic        soft_rst_o,
  input logic        mmu_cmd_vld_o,
  input logic        mem_we_o
);
  logic acc;
  assign acc = (wr_i || rd_i) && bank_q == 2'd2 && addr_i[3:2] == 2'b10;

  AST_PTR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ptr_q[14] |=> ptr_q[10:0] == $past(ptr_q[10:0]) + 11'd1 &&
                         ptr_q[15:11] == $past(ptr_q[15:11])); // R4
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !ptr_q[14] |=> $stable(ptr_q)); // R5
  AST_ACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && bank_q == 2'd2 && addr_i == 4'd12 && wdata_i[4] && !irq_set_i[4]
    |=> !stat_q[4]); // R6
  AST_MASK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && bank_q == 2'd2 && addr_i == 4'd13 && wdata_i == 8'h00 |=> !irq_o); // R7
  AST_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !irq_o && bank_q == 2'd0 && ptr_q == 16'h0); // R8
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({soft_rst_o, mmu_cmd_vld_o, mem_we_o})); // R11
endmodule

bind nic_host_regs bhi_checks u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .irq_set_i,
  .bank_q (bank_q), .ptr_q (ptr_q), .stat_q (stat_q),
  .irq_o, .soft_rst_o, .mmu_cmd_vld_o, .mem_we_o
);

// File: tb/tb_nic_host_regs.sv
module tb_nic_host_regs;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [3:0]  addr = 0;
  logic        wr = 0, rd = 0;
  logic [7:0]  wdata = 0, rdata;
  logic [12:0] mem_addr;
  logic        mem_we, mmu_vld, pop, srst, irq;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [2:0]  mmu_cmd;
  logic [7:0]  rx_head = 8'h01, txd_head = 8'h80, alloc_res = 8'h02, alloc_cnt = 8'h03;
  logic [7:0]  iset = 0;
  logic        txq_empty = 1, txd_ne = 0;

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {1'b0, a[12:11], 5'h15};
  endfunction
  assign mem_rdata = pat(mem_addr);

  nic_host_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .rx_head_i(rx_head),
    .tx_done_head_i(txd_head), .alloc_res_i(alloc_res), .alloc_cnt_i(alloc_cnt),
    .irq_set_i(iset), .txq_empty_i(txq_empty), .txdone_ne_i(txd_ne),
    .mmu_cmd_vld_o(mmu_vld), .mmu_cmd_o(mmu_cmd), .tx_done_pop_o(pop),
    .soft_rst_o(srst), .irq_o(irq));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model
  logic [1:0]  m_bank;
  logic [15:0] m_tcr, m_rcr, m_cfg, m_ctl, m_gp, m_ptr;
  logic [7:0]  m_pnum, m_stat, m_mask;
  logic [4:0]  m_ercv;

  task automatic m_reset();
    m_bank = 0; m_tcr = 0; m_rcr = 0; m_cfg = 16'hA0B1; m_ctl = 16'h1210;
    m_gp = 0; m_ptr = 0; m_pnum = 0; m_stat = 8'h04; m_mask = 0; m_ercv = 5'h1F;
  endtask
  initial m_reset();

  function automatic logic [12:0] m_addr(input logic [1:0] lane);
    logic [1:0] pg;
    logic [10:0] b;
    pg = m_ptr[15] ? rx_head[1:0] : m_pnum[1:0];
    b  = m_ptr[14] ? m_ptr[10:0] : m_ptr[10:0] + {9'b0, lane};
    return {pg, b};
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a == 14) return {6'b0, m_bank};
    if (a == 15) return 8'h33;
    case (m_bank)
      2'd0: case (a) 0: return m_tcr[7:0]; 1: return m_tcr[15:8]; 3: return 8'h40;
              4: return m_rcr[7:0]; 5: return m_rcr[15:8]; 8: return 8'd4;
              9: return alloc_cnt; default: return 0; endcase
      2'd1: case (a) 0: return m_cfg[7:0]; 1: return m_cfg[15:8]; 10: return m_gp[7:0];
              11: return m_gp[15:8]; 12: return m_ctl[7:0]; 13: return m_ctl[15:8];
              default: return 0; endcase
      2'd2: case (a) 2: return m_pnum; 3: return alloc_res; 4: return txd_head;
              5: return rx_head; 6: return m_ptr[7:0]; 7: return m_ptr[15:8] & 8'hF7;
              8, 9, 10, 11: return pat(m_addr(a[1:0]));
              12: return m_stat; 13: return m_mask; default: return 0; endcase
      default: case (a) 8: return 8'h30; 9: return 8'h33; 10: return 8'h91;
              11: return 8'h33; 12: return {3'b0, m_ercv}; default: return 0; endcase
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      logic [7:0] ackm;
      logic bk2, dacc;
      bk2  = m_bank == 2 && addr != 14 && addr != 15;
      dacc = (wr || rd) && bk2 && addr[3:2] == 2'b10;
      ackm = (wr && bk2 && addr == 12) ? (wdata & 8'hD6) : 8'h00;
      m_stat = (m_stat & ~ackm) | iset | {5'b0, txq_empty, txd_ne, 1'b0};
      if (dacc && m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
      if (wr) begin
        if (addr == 14) m_bank = wdata[1:0];
        else if (addr != 15) case (m_bank)
          2'd0: case (addr) 0: m_tcr[7:0] = wdata; 1: m_tcr[15:8] = wdata;
                  4: m_rcr[7:0] = wdata; 5: m_rcr[15:8] = wdata; default: ; endcase
          2'd1: case (addr) 0: m_cfg[7:0] = wdata; 1: m_cfg[15:8] = wdata;
                  10: m_gp[7:0] = wdata; 11: m_gp[15:8] = wdata;
                  12: m_ctl[7:0] = wdata & 8'hFC; 13: m_ctl[15:8] = wdata; default: ; endcase
          2'd2: case (addr) 2: m_pnum = wdata; 6: m_ptr[7:0] = wdata;
                  7: m_ptr[15:8] = wdata; 13: m_mask = wdata; default: ; endcase
          default: if (addr == 12) m_ercv = wdata[4:0];
        endcase
        if (m_bank == 0 && addr == 5 && wdata[7]) m_reset();
      end
    end
  end

  // interrupt level compared on every clock, away from the edge
  always @(negedge clk) if (rst_n) chk("R7 irq level", irq, |(m_stat & m_mask));

  task automatic wr_b(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    #1;
    if (m_bank == 2 && a[3:2] == 2'b10) begin
      chk("R3 write page/addr", mem_addr, m_addr(a[1:0]));
      chk("R3 write strobe", mem_we, 1);
      chk("R3 write data", mem_wdata, d);
    end
    chk("R6 pop", pop, m_bank == 2 && a == 12 && d[1]);
    chk("R8 soft reset strobe", srst, m_bank == 0 && a == 5 && d[7]);
    chk("R11 cmd strobe", mmu_vld, m_bank == 2 && a == 0);
    if (m_bank == 2 && a == 0) chk("R11 cmd code", mmu_cmd, d[7:5]);
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic rd_b(input string req, input logic [3:0] a);
    @(negedge clk);
    addr = a; rd = 1;
    #1;
    chk(req, rdata, m_read(a));
    if (m_bank == 2 && a[3:2] == 2'b10) chk({req, " addr"}, mem_addr, m_addr(a[1:0]));
    @(posedge clk); #1;
    rd = 0;
  endtask

  task automatic rd_exp(input string req, input logic [3:0] a, input logic [7:0] e);
    @(negedge clk);
    addr = a; rd = 1;
    #1;
    chk(req, rdata, e);
    @(posedge clk); #1;
    rd = 0;
  endtask

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset values
    rd_exp("R2 bank", 14, 0);
    rd_exp("R2 tcr", 0, 0);
    rd_exp("R2 rcr hi", 5, 0);
    wr_b(14, 1);
    rd_exp("R2 cfg lo", 0, 8'hB1);
    rd_exp("R2 cfg hi", 1, 8'hA0);
    rd_exp("R2 ctl lo", 12, 8'h10);
    rd_exp("R2 ctl hi", 13, 8'h12);
    wr_b(14, 2);
    rd_exp("R2 ptr lo", 6, 0);
    rd_exp("R2 status", 12, 8'h04);
    rd_exp("R2 mask", 13, 0);
    wr_b(14, 3);
    rd_exp("R2 ercv", 12, 8'h1F);
    // R1 bank selector and signature
    for (int b = 0; b < 4; b++) begin
      wr_b(14, 8'(b));
      rd_exp("R1 bank readback", 14, 8'(b));
      rd_exp("R1 offset 15", 15, 8'h33);
    end
    wr_b(15, 8'hAA);
    rd_exp("R1 offset 15 after write", 15, 8'h33);
    rd_exp("R1 bank kept", 14, 3);
    // R9 constants and masked pointer
    rd_exp("R9 revision", 10, 8'h91);
    wr_b(14, 0);
    rd_exp("R9 page count", 8, 4);
    rd_exp("R9 alloc count", 9, 3);
    wr_b(14, 2);
    wr_b(7, 8'hFF);
    rd_exp("R9 ptr hi masked", 7, 8'hF7);
    // R10 control low byte
    wr_b(14, 1);
    wr_b(12, 8'hFF);
    rd_exp("R10 control lo", 12, 8'hFC);
    wr_b(13, 8'h5A);
    rd_b("R10 control hi", 13);
    // R3/R4 auto-increment with wrap, packet-number page
    wr_b(14, 2);
    wr_b(2, 8'h02);
    wr_b(6, 8'hFE); wr_b(7, 8'h47);   // ptr 0x47FE: inc, page from pnum
    wr_b(8, 8'h11);
    wr_b(9, 8'h22);                   // lane ignored in inc mode
    rd_b("R4 inc read at 000", 10);
    rd_exp("R4 ptr lo after wrap", 6, 8'h01);
    rd_exp("R4 ptr hi kept", 7, 8'h40);
    // R3/R5 offset mode, RX-head page
    wr_b(6, 8'h10); wr_b(7, 8'h80);   // ptr 0x8010
    for (int l = 0; l < 4; l++) rd_b("R5 lane read", 4'(8 + l));
    rd_exp("R5 ptr unchanged", 6, 8'h10);
    rx_head = 8'h03;
    wr_b(6, 8'hFF); wr_b(7, 8'h87);   // ptr 0x87FF, sum wraps
    rd_b("R5 wrap read", 11);
    wr_b(11, 8'h77);
    rd_exp("R5 ptr hi unchanged", 7, 8'h87);
    wr_b(7, 8'h00);
    rd_b("R3 pnum page read", 8);
    // R6/R7 interrupts
    wr_b(13, 8'h11);
    @(negedge clk); iset = 8'h01; @(negedge clk); iset = 0;
    rd_b("R7 rcv set", 12);
    wr_b(12, 8'h01);                  // not in clear mask
    rd_exp("R6 bit0 not cleared", 12, 8'h05);
    @(negedge clk); iset = 8'h10; @(negedge clk); iset = 0;
    wr_b(12, 8'h10);
    rd_exp("R6 bit4 cleared", 12, 8'h05);
    wr_b(12, 8'h04);
    rd_exp("R7 tx empty forced", 12, 8'h05);
    txd_ne = 1;
    wr_b(13, 8'h02);
    wr_b(12, 8'h02);
    rd_exp("R7 tx forced", 12, 8'h07);
    txd_ne = 0; txq_empty = 0;
    wr_b(12, 8'h06);
    rd_exp("R6 tx bits cleared", 12, 8'h01);
    wr_b(13, 8'h00);
    // R11 command strobe
    wr_b(0, 8'h40);
    wr_b(0, 8'hE0);
    // R8 soft reset
    wr_b(13, 8'hFF);
    wr_b(14, 0);
    wr_b(0, 8'h55);
    wr_b(5, 8'h80);
    rd_exp("R8 bank reset", 14, 0);
    rd_exp("R8 tcr reset", 0, 0);
    rd_exp("R8 rcr reset", 5, 0);
    wr_b(14, 2);
    rd_exp("R8 mask reset", 13, 0);
    rd_exp("R8 ptr reset", 7, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule